// File: doc/BRIEF.md
# Register Access Validator

This block sits in front of a register bank and screens every bus access before register logic sees it. It compares the access offset against a table of register regions fixed at elaboration time. Each region has a base offset, a byte length, a set of permitted access widths, a bits-per-interrupt count and a kind. All table entries are compared in parallel. The block then checks the access length, the width permitted by the matched region, the natural alignment, and an interrupt-number bound derived from the region's bits-per-interrupt.

A valid access to a live region is forwarded to the bank one cycle later. The forwarded access carries the region index and the offset relative to the region base. Two kinds of access never reach the bank: an access that fails any check, and an access to a helper region. Such an access is answered by the block itself. A rejected read returns zero and a rejected write is dropped. A read-as-ones helper region returns all ones across the accessed bytes. A read-as-zero helper region returns zero. Both helper kinds ignore writes.

The bus carries data little-endian, and the host side of the bank uses the opposite byte order. The block therefore reverses the accessed bytes of write data on the way in and of read data on the way out, and zeroes every byte above the access length. A single-byte access passes through unchanged.

Top module: `reg_access_gate`

## Requirements
- R1: An access matches region i only when base_i <= addr < base_i + len_i. An access that matches no region is not forwarded. If it is a read, it returns zero.
- R2: Only access lengths of 1, 4 and 8 bytes are legal. Any other length is rejected: it is not forwarded and a read returns zero.
- R3: Each region has a width mask. Bit 0 permits 8-bit access, bit 1 permits 32-bit access and bit 2 permits 64-bit access. An access whose width is not permitted by the matched region is rejected.
- R4: The address must be a multiple of the access length. A misaligned access is rejected.
- R5: For a region with nonzero bits-per-interrupt b, the interrupt number is (addr - base) * 8 / b. This number must be below PRIV_IRQS plus the `shared_irqs` input, or the access is rejected. A region with b = 0 skips this check.
- R6: A rejected read returns all zeros. A rejected write is never forwarded. Every write response carries zero read data.
- R7: Every request produces `rsp_valid` exactly one cycle later. A forwarded access raises `fwd_valid` in that same cycle. It also presents, in that cycle, the region index, the region-relative offset, the length and the write flag.
- R8: Forwarded write data holds the low `len` bus bytes in reversed order, with all higher bytes zero. A 1-byte write passes its byte unchanged.
- R9: Read data for a forwarded read is `bank_rdata`, taken in the response cycle, with its low `len` bytes reversed and all higher bytes zero.
- R10: A valid read to a read-as-ones region returns 0xFF in each of the `len` low bytes and zero above. A read-as-zero region reads zero. Neither helper kind forwards reads or writes.
- R11: While and after reset, until the first request, `fwd_valid`, `rsp_valid` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, little-endian bus lanes |
| shared_irqs | input | SHARED_W | Number of configured shared interrupts |
| fwd_valid | output | 1 | Validated access presented to the bank |
| fwd_write | output | 1 | Forwarded access is a write |
| fwd_region | output | RIDX_W | Index of the matched region |
| fwd_offset | output | ADDR_W | Offset relative to the region base |
| fwd_len | output | 4 | Access length in bytes |
| fwd_wdata | output | 64 | Write data in host byte order |
| bank_rdata | input | 64 | Bank read data in host byte order, during `fwd_valid` |
| rsp_valid | output | 1 | Response for the previous-cycle request |
| rsp_rdata | output | 64 | Read data in bus byte order |

## Verification
Every result is due on the first rising edge after the request is sampled. This covers `rsp_valid`, `fwd_valid` and the forwarded fields. `rsp_rdata` for a forwarded read is a combinational function of `bank_rdata` within that same response cycle.

The bench drives a request on a falling edge and checks all outputs on the next falling edge, half a period after the registering edge. It holds `bank_rdata` steady through that check. It then idles one cycle before the next request, so that no two responses overlap.

// File: rtl/rag_pkg.sv
package rag_pkg;

  typedef enum logic [1:0] {
    RK_LIVE = 2'd0,
    RK_ZERO = 2'd1,
    RK_ONES = 2'd2
  } rgn_kind_e;

  localparam int BUS_BYTES = 8;
  localparam int BUS_W     = 64;

  localparam logic [2:0] WF_8  = 3'b001;
  localparam logic [2:0] WF_32 = 3'b010;
  localparam logic [2:0] WF_64 = 3'b100;

  // width flag for a byte length; zero means an illegal length
  function automatic logic [2:0] len_flag(input logic [3:0] len);
    case (len)
      4'd1:    return WF_8;
      4'd4:    return WF_32;
      4'd8:    return WF_64;
      default: return 3'b000;
    endcase
  endfunction

  // interrupt number covered by a region-relative byte offset
  function automatic logic [31:0] irq_of(input logic [31:0] rel, input logic [7:0] bpi);
    logic [34:0] bits;
    bits = {rel, 3'b000};
    case (bpi)
      8'd1:    return bits[31:0];
      8'd2:    return bits[32:1];
      8'd4:    return bits[33:2];
      8'd8:    return bits[34:3];
      8'd16:   return {1'b0, bits[34:4]};
      8'd32:   return {2'b0, bits[34:5]};
      8'd64:   return {3'b0, bits[34:6]};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int clamp_len(input logic [3:0] len);
    return (len > 4'd8) ? BUS_BYTES : int'(len);
  endfunction

  // keep the low len bytes, zero the rest
  function automatic logic [BUS_W-1:0] lane_mask(input logic [BUS_W-1:0] d, input logic [3:0] len);
    logic [BUS_W-1:0] r;
    int n;
    r = '0;
    n = clamp_len(len);
    for (int i = 0; i < BUS_BYTES; i++)
      if (i < n) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // reverse the low len bytes, zero the rest
  function automatic logic [BUS_W-1:0] lane_swap(input logic [BUS_W-1:0] d, input logic [3:0] len);
    logic [BUS_W-1:0] r;
    int n;
    r = '0;
    n = clamp_len(len);
    for (int i = 0; i < BUS_BYTES; i++)
      if (i < n) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/rag_region_match.sv
module rag_region_match #(
  parameter int NUM_REGIONS = 6,
  parameter int ADDR_W      = 12,
  parameter int RIDX_W      = 3,
  parameter logic [NUM_REGIONS-1:0][31:0] RGN_BASE = '0,
  parameter logic [NUM_REGIONS-1:0][31:0] RGN_LEN  = '0
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic                   hit,
  output logic [NUM_REGIONS-1:0] sel,
  output logic [RIDX_W-1:0]      idx,
  output logic [ADDR_W-1:0]      rel_off
);

  localparam int EXT_W = 33;

  logic [EXT_W-1:0] addr_ext;
  assign addr_ext = EXT_W'(addr);

  // one comparator pair per table entry, all in parallel
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic [EXT_W-1:0] lo_ext;
    logic [EXT_W-1:0] hi_ext;
    assign lo_ext = {1'b0, RGN_BASE[g]};
    assign hi_ext = {1'b0, RGN_BASE[g]} + {1'b0, RGN_LEN[g]};
    assign sel[g] = (addr_ext >= lo_ext) && (addr_ext < hi_ext);
  end

  assign hit = |sel;

  always_comb begin
    idx     = '0;
    rel_off = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (sel[i]) begin
        idx     = RIDX_W'(i);
        rel_off = addr - RGN_BASE[i][ADDR_W-1:0];
      end
    end
  end

endmodule

// File: rtl/rag_access_check.sv
module rag_access_check #(
  parameter int ADDR_W    = 12,
  parameter int SHARED_W  = 10,
  parameter int PRIV_IRQS = 32
) (
  input  logic [3:0]          len,
  input  logic [2:0]          addr_lo,
  input  logic [2:0]          widths,
  input  logic [7:0]          bpi,
  input  logic [ADDR_W-1:0]   rel_off,
  input  logic [SHARED_W-1:0] shared_irqs,
  output logic                len_ok,
  output logic                width_ok,
  output logic                align_ok,
  output logic                bound_ok
);
  import rag_pkg::*;

  logic [2:0]  flag;
  logic [31:0] irq_num;
  logic [31:0] irq_limit;

  assign flag     = len_flag(len);
  assign len_ok   = (flag != 3'b000);
  assign width_ok = ((flag & widths) != 3'b000);

  always_comb begin
    case (len)
      4'd1:    align_ok = 1'b1;
      4'd4:    align_ok = (addr_lo[1:0] == 2'b00);
      4'd8:    align_ok = (addr_lo == 3'b000);
      default: align_ok = 1'b0;
    endcase
  end

  assign irq_num   = irq_of(32'(rel_off), bpi);
  assign irq_limit = 32'(PRIV_IRQS) + 32'(shared_irqs);
  assign bound_ok  = (bpi == 8'd0) || (irq_num < irq_limit);

endmodule

// File: rtl/rag_lane_conv.sv
module rag_lane_conv #(
  parameter bit SWAP = 1'b1
) (
  input  logic [63:0] din,
  input  logic [3:0]  len,
  output logic [63:0] dout
);
  import rag_pkg::*;

  if (SWAP) begin : g_swap
    assign dout = lane_swap(din, len);
  end else begin : g_pass
    assign dout = lane_mask(din, len);
  end

endmodule

// File: rtl/reg_access_gate.sv
module reg_access_gate #(
  parameter int ADDR_W      = 12,
  parameter int SHARED_W    = 10,
  parameter int PRIV_IRQS   = 32,
  parameter bit SWAP_LANES  = 1'b1,
  parameter int NUM_REGIONS = 6,
  parameter logic [NUM_REGIONS-1:0][31:0] RGN_BASE =
    {32'h0F00, 32'h0C00, 32'h0400, 32'h0080, 32'h0008, 32'h0000},
  parameter logic [NUM_REGIONS-1:0][31:0] RGN_LEN =
    {32'h0010, 32'h0100, 32'h0400, 32'h0080, 32'h0008, 32'h0004},
  parameter logic [NUM_REGIONS-1:0][2:0] RGN_WIDTHS =
    {3'b110, 3'b010, 3'b011, 3'b010, 3'b110, 3'b010},
  parameter logic [NUM_REGIONS-1:0][7:0] RGN_BPI =
    {8'd0, 8'd2, 8'd8, 8'd1, 8'd0, 8'd0},
  parameter logic [NUM_REGIONS-1:0][1:0] RGN_KIND =
    {2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0},
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [3:0]          req_len,
  input  logic [63:0]         req_wdata,
  input  logic [SHARED_W-1:0] shared_irqs,
  output logic                fwd_valid,
  output logic                fwd_write,
  output logic [RIDX_W-1:0]   fwd_region,
  output logic [ADDR_W-1:0]   fwd_offset,
  output logic [3:0]          fwd_len,
  output logic [63:0]         fwd_wdata,
  input  logic [63:0]         bank_rdata,
  output logic                rsp_valid,
  output logic [63:0]         rsp_rdata
);
  import rag_pkg::*;

  // named events of the decode path
  logic                   rgn_hit;
  logic [NUM_REGIONS-1:0] rgn_sel;
  logic [RIDX_W-1:0]      rgn_idx;
  logic [ADDR_W-1:0]      rgn_rel;
  logic [2:0]             sel_widths;
  logic [7:0]             sel_bpi;
  rgn_kind_e              sel_kind;
  logic                   len_ok;
  logic                   width_ok;
  logic                   align_ok;
  logic                   bound_ok;
  logic                   acc_ok;
  logic                   take_fwd;
  logic                   take_ones;
  logic [63:0]            wdata_host;
  logic [63:0]            rdata_bus;

  rag_region_match #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W),
    .RIDX_W     (RIDX_W),
    .RGN_BASE   (RGN_BASE),
    .RGN_LEN    (RGN_LEN)
  ) u_match (
    .addr   (req_addr),
    .hit    (rgn_hit),
    .sel    (rgn_sel),
    .idx    (rgn_idx),
    .rel_off(rgn_rel)
  );

  always_comb begin
    sel_widths = 3'b000;
    sel_bpi    = 8'd0;
    sel_kind   = RK_ZERO;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (rgn_sel[i]) begin
        sel_widths = RGN_WIDTHS[i];
        sel_bpi    = RGN_BPI[i];
        sel_kind   = rgn_kind_e'(RGN_KIND[i]);
      end
    end
  end

  rag_access_check #(
    .ADDR_W   (ADDR_W),
    .SHARED_W (SHARED_W),
    .PRIV_IRQS(PRIV_IRQS)
  ) u_check (
    .len        (req_len),
    .addr_lo    (req_addr[2:0]),
    .widths     (sel_widths),
    .bpi        (sel_bpi),
    .rel_off    (rgn_rel),
    .shared_irqs(shared_irqs),
    .len_ok     (len_ok),
    .width_ok   (width_ok),
    .align_ok   (align_ok),
    .bound_ok   (bound_ok)
  );

  assign acc_ok    = rgn_hit && len_ok && width_ok && align_ok && bound_ok;
  assign take_fwd  = acc_ok && (sel_kind == RK_LIVE);
  assign take_ones = acc_ok && (sel_kind == RK_ONES) && !req_write;

  rag_lane_conv #(.SWAP(SWAP_LANES)) u_wconv (
    .din (req_wdata),
    .len (req_len),
    .dout(wdata_host)
  );

  // response-stage state
  logic              q_rsp;
  logic              q_fwd;
  logic              q_ones;
  logic              q_write;
  logic [RIDX_W-1:0] q_region;
  logic [ADDR_W-1:0] q_off;
  logic [3:0]        q_len;
  logic [63:0]       q_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rsp    <= 1'b0;
      q_fwd    <= 1'b0;
      q_ones   <= 1'b0;
      q_write  <= 1'b0;
      q_region <= '0;
      q_off    <= '0;
      q_len    <= '0;
      q_wdata  <= '0;
    end else begin
      q_rsp   <= req_valid;
      q_fwd   <= req_valid && take_fwd;
      q_ones  <= req_valid && take_ones;
      q_write <= req_write;
      if (req_valid) begin
        q_region <= rgn_idx;
        q_off    <= rgn_rel;
        q_len    <= req_len;
        q_wdata  <= (take_fwd && req_write) ? wdata_host : 64'd0;
      end
    end
  end

  rag_lane_conv #(.SWAP(SWAP_LANES)) u_rconv (
    .din (bank_rdata),
    .len (q_len),
    .dout(rdata_bus)
  );

  assign fwd_valid  = q_fwd;
  assign fwd_write  = q_write;
  assign fwd_region = q_region;
  assign fwd_offset = q_off;
  assign fwd_len    = q_len;
  assign fwd_wdata  = q_wdata;
  assign rsp_valid  = q_rsp;

  always_comb begin
    if (q_rsp && !q_write && q_fwd)
      rsp_rdata = rdata_bus;
    else if (q_rsp && !q_write && q_ones)
      rsp_rdata = lane_mask({64{1'b1}}, q_len);
    else
      rsp_rdata = 64'd0;
  end

endmodule

// File: rtl/rag_checker.sv
module rag_checker #(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 6,
  parameter int RIDX_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_len,
  input logic              rgn_hit,
  input logic              fwd_valid,
  input logic              fwd_write,
  input logic [RIDX_W-1:0] fwd_region,
  input logic [3:0]        fwd_len,
  input logic [63:0]       fwd_wdata,
  input logic              rsp_valid,
  input logic [63:0]       rsp_rdata
);

  logic bad_len;
  logic misaligned;
  assign bad_len    = !(req_len == 4'd1 || req_len == 4'd4 || req_len == 4'd8);
  assign misaligned = (req_len == 4'd4 && req_addr[1:0] != 2'b00) ||
                      (req_len == 4'd8 && req_addr[2:0] != 3'b000);

  assert_nohit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rgn_hit) |=> (!fwd_valid && rsp_rdata == 64'd0));

  assert_region_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (32'(fwd_region) < NUM_REGIONS));

  assert_bad_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_len) |=> (!fwd_valid && rsp_rdata == 64'd0));

  assert_misaligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && misaligned) |=> (!fwd_valid && rsp_rdata == 64'd0));

  assert_write_zero_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 64'd0));

  assert_fwd_has_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> rsp_valid);

  assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid && fwd_write == $past(req_write)));

  assert_idle_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !fwd_valid));

  assert_wlanes4_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_write && fwd_len == 4'd4) |-> (fwd_wdata[63:32] == 32'd0));

  assert_wlanes1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_write && fwd_len == 4'd1) |-> (fwd_wdata[63:8] == 56'd0));

endmodule

bind reg_access_gate rag_checker #(
  .ADDR_W     (ADDR_W),
  .NUM_REGIONS(NUM_REGIONS),
  .RIDX_W     (RIDX_W)
) u_rag_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .rgn_hit   (rgn_hit),
  .fwd_valid (fwd_valid),
  .fwd_write (fwd_write),
  .fwd_region(fwd_region),
  .fwd_len   (fwd_len),
  .fwd_wdata (fwd_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/reg_access_gate_test.sv
`timescale 1ns/1ps
module reg_access_gate_test;

  localparam int ADDR_W   = 12;
  localparam int SHARED_W = 10;
  localparam int RIDX_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_len = 4'd0;
  logic [63:0]       req_wdata = '0;
  logic [SHARED_W-1:0] shared_irqs = 10'd32;
  logic              fwd_valid;
  logic              fwd_write;
  logic [RIDX_W-1:0] fwd_region;
  logic [ADDR_W-1:0] fwd_offset;
  logic [3:0]        fwd_len;
  logic [63:0]       fwd_wdata;
  logic [63:0]       bank_rdata = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reg_access_gate uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_wdata  (req_wdata),
    .shared_irqs(shared_irqs),
    .fwd_valid  (fwd_valid),
    .fwd_write  (fwd_write),
    .fwd_region (fwd_region),
    .fwd_offset (fwd_offset),
    .fwd_len    (fwd_len),
    .fwd_wdata  (fwd_wdata),
    .bank_rdata (bank_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [3:0]        len;
    logic [63:0]       wdata;
    logic [63:0]       bank;
    logic              efwd;
    logic [RIDX_W-1:0] ereg;
    logic [ADDR_W-1:0] eoff;
    logic [63:0]       erdata;
    logic [63:0]       ewdata;
    logic [7:0]        rq;
  } vec_t;

  localparam int NV = 23;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  // shared_irqs = 32, so the interrupt limit is 64
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 4'd4, 64'h0, 64'h0000_0000_A1B2_C3D4, 1'b1, 3'd0, 12'h000, 64'h0000_0000_D4C3_B2A1, 64'h0, 8'd9},  // R9
    '{1'b1, 12'h000, 4'd4, 64'hFFFF_FFFF_1122_3344, 64'h0, 1'b1, 3'd0, 12'h000, 64'h0, 64'h0000_0000_4433_2211, 8'd8}, // R8
    '{1'b0, 12'h004, 4'd4, 64'h0, 64'h55, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd1},                                   // R1 gap
    '{1'b0, 12'h008, 4'd8, 64'h0, 64'h1234, 1'b0, 3'd0, 12'h000, ONES, 64'h0, 8'd10},                                 // R10 ones
    '{1'b0, 12'h008, 4'd4, 64'h0, 64'h1234, 1'b0, 3'd0, 12'h000, 64'h0000_0000_FFFF_FFFF, 64'h0, 8'd10},             // R10
    '{1'b0, 12'h00C, 4'd4, 64'h0, 64'h0, 1'b0, 3'd0, 12'h000, 64'h0000_0000_FFFF_FFFF, 64'h0, 8'd10},                // R10
    '{1'b0, 12'h000, 4'd8, 64'h0, 64'hDEAD, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd3},                                 // R3
    '{1'b0, 12'h084, 4'd4, 64'h0, 64'hFF, 1'b1, 3'd2, 12'h004, 64'h0000_0000_FF00_0000, 64'h0, 8'd5},                // R5 irq 32
    '{1'b0, 12'h088, 4'd4, 64'h0, 64'hFF, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd5},                                   // R5 irq 64
    '{1'b1, 12'h43F, 4'd1, 64'hAAAA_AAAA_AAAA_AA5A, 64'h0, 1'b1, 3'd3, 12'h03F, 64'h0, 64'h5A, 8'd8},               // R8 R5
    '{1'b1, 12'h440, 4'd1, 64'h5A, 64'h0, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd6},                                   // R6 R5
    '{1'b0, 12'h402, 4'd4, 64'h0, 64'h1, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd4},                                    // R4
    '{1'b0, 12'h400, 4'd2, 64'h0, 64'h1, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd2},                                    // R2
    '{1'b0, 12'hC0C, 4'd4, 64'h0, 64'h0102_0304_0506_0708, 1'b1, 3'd4, 12'h00C, 64'h0000_0000_0807_0605, 64'h0, 8'd9}, // R9
    '{1'b0, 12'hC10, 4'd4, 64'h0, 64'h1, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd5},                                    // R5
    '{1'b0, 12'hF00, 4'd8, 64'h0, 64'h77, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd10},                                  // R10 zero
    '{1'b1, 12'hF08, 4'd8, 64'h1234, 64'h0, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd10},                                // R10
    '{1'b0, 12'h400, 4'd8, 64'h0, 64'h9, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd3},                                    // R3
    '{1'b0, 12'h100, 4'd4, 64'h0, 64'h9, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd1},                                    // R1
    '{1'b0, 12'h401, 4'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFAB, 1'b1, 3'd3, 12'h001, 64'hAB, 64'h0, 8'd9},               // R9
    '{1'b0, 12'h008, 4'd1, 64'h0, 64'h0, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd3},                                    // R3
    '{1'b1, 12'h008, 4'd8, 64'h1, 64'h0, 1'b0, 3'd0, 12'h000, 64'h0, 64'h0, 8'd10},                                   // R10
    '{1'b1, 12'h400, 4'd4, 64'h0000_0000_0A0B_0C0D, 64'h0, 1'b1, 3'd3, 12'h000, 64'h0, 64'h0000_0000_0D0C_0B0A, 8'd8} // R8
  };

  task automatic check_eq(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive on a falling edge; results are checked at the next falling edge
  task automatic issue(input logic wr, input logic [ADDR_W-1:0] addr,
                       input logic [3:0] len, input logic [63:0] wd,
                       input logic [63:0] bank);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = addr;
    req_len    = len;
    req_wdata  = wd;
    bank_rdata = bank;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check_eq("R11", "fwd_valid in reset", 64'(fwd_valid), 64'd0);
    check_eq("R11", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R11", "fwd_valid after reset", 64'(fwd_valid), 64'd0);
    check_eq("R11", "rsp_rdata after reset", rsp_rdata, 64'd0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].rq, v);
      issue(VECS[v].wr, VECS[v].addr, VECS[v].len, VECS[v].wdata, VECS[v].bank);
      check_eq(tg, "rsp_valid (R7)", 64'(rsp_valid), 64'd1);
      check_eq(tg, "fwd_valid", 64'(fwd_valid), 64'(VECS[v].efwd));
      check_eq(tg, "rsp_rdata", rsp_rdata, VECS[v].erdata);
      if (VECS[v].efwd) begin
        check_eq(tg, "fwd_region (R7)", 64'(fwd_region), 64'(VECS[v].ereg));
        check_eq(tg, "fwd_offset (R7)", 64'(fwd_offset), 64'(VECS[v].eoff));
        check_eq(tg, "fwd_len (R7)", 64'(fwd_len), 64'(VECS[v].len));
        check_eq(tg, "fwd_write (R7)", 64'(fwd_write), 64'(VECS[v].wr));
        if (VECS[v].wr) check_eq(tg, "fwd_wdata", fwd_wdata, VECS[v].ewdata);
      end
      settle();
    end

    // R7 idle cycle gives no response
    settle();
    check_eq("R7", "idle rsp_valid", 64'(rsp_valid), 64'd0);
    check_eq("R7", "idle fwd_valid", 64'(fwd_valid), 64'd0);

    // R5 with no shared interrupts: limit is 32
    shared_irqs = 10'd0;
    issue(1'b0, 12'h084, 4'd4, 64'h0, 64'hFF);
    check_eq("R5", "irq 32 over limit 32", 64'(fwd_valid), 64'd0);
    check_eq("R5", "irq 32 rdata", rsp_rdata, 64'd0);
    settle();
    issue(1'b0, 12'h080, 4'd4, 64'h0, 64'h0000_0000_0000_0011);
    check_eq("R5", "irq 0 forwarded", 64'(fwd_valid), 64'd1);
    check_eq("R9", "irq 0 rdata", rsp_rdata, 64'h0000_0000_1100_0000);
    settle();
    issue(1'b0, 12'h000, 4'd4, 64'h0, 64'h0);
    check_eq("R5", "zero bpi region skips bound", 64'(fwd_valid), 64'd1);
    settle();

    // R5 exact edge: limit 63
    shared_irqs = 10'd31;
    issue(1'b1, 12'h43F, 4'd1, 64'h3C, 64'h0);
    check_eq("R5", "irq 63 at limit 63", 64'(fwd_valid), 64'd0);
    settle();
    issue(1'b1, 12'h43E, 4'd1, 64'h3C, 64'h0);
    check_eq("R5", "irq 62 below limit", 64'(fwd_valid), 64'd1);
    check_eq("R7", "irq 62 offset", 64'(fwd_offset), 64'h03E);
    check_eq("R8", "byte write data", fwd_wdata, 64'h3C);
    settle();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule